// File: doc/BRIEF.md
# Pixel-plot bank-mapping window

This block maps a 4 KB host address window onto cartridge memory. The window has three regions. The bottom 256 bytes show one selectable page of internal RAM. The middle 1792 bytes show most of a selectable 2 KB block, taken from either RAM or flash. The top 2 KB show a selectable 2 KB flash block. A control port outside the window writes the bank registers and a mode register.

Two optional helper modes speed up plotting pixels into a RAM bitmap. The first is page steering. Any access in the top page (offsets 0xF00–0xFFF) re-aims the 256-byte window at a page chosen by bits of the access address. The second is mask latching. A read in the top page latches the flash byte it returns, together with address bit 7. The next access to the 256-byte window then ANDs or ORs that byte into RAM in a single cycle. With both modes on, plotting a pixel takes two host accesses. The first reads a mask-table entry, and the second touches the bitmap byte.

Flash contents are produced by a fixed function of the flash address, so no storage is needed for them.

Top module: `pixel_bank_mapper`

## Requirements
- R1: A host access at offset o < 0x100 reaches RAM byte page*256 + o. The page number is written through control select 0, using the low RAM_AW-8 bits of the control data.
- R2: Control select 1 sets up the middle region. Data bit 7 chooses flash (1) or RAM (0), and the low bits give the block number b. An access at offset o in 0x100–0x7FF reaches byte b*2048 + o of the chosen memory.
- R3: Control select 2 gives the flash block h for the top region. An access at offset o in 0x800–0xFFF reads flash byte h*2048 + (o & 0x7FF). The flash byte at 16-bit address a is a[7:0] ^ {a[11:8], a[15:12]} ^ 0x5A.
- R4: Control select 3 is the mode register. Bit 0 write-protects the 256-byte window and bit 1 write-protects the middle region when it maps RAM. A protected write leaves RAM unchanged. Writes to flash never change anything. An unprotected RAM location reads back what was last written to it.
- R5: A read strobe in one cycle places the data on host_rdata from the next cycle on. The value holds until the next read strobe, and writes do not disturb it.
- R6: When mode bit 2 is set, any read or write at 0xF00–0xFFF sets the page number. Page bit 3 takes address bit 3 and page bits 2..0 take address bits 6..4. The new page applies from the next access on.
- R7: When mode bit 3 is set, a read at 0xF00–0xFFF returns the top-region flash byte as usual. That read also latches this byte as a mask, with address bit 7 as the operation selector.
- R8: While a mask is latched, the next access to the 256-byte window replaces the RAM byte in one cycle. The new value is old AND mask if the selector is 1, and old OR mask if it is 0. The host write data is ignored. A read returns the byte as it was before the change. If the window is write-protected, RAM stays unchanged.
- R9: One window access uses up a latched mask, even when protection blocks the change. A later window access is plain again. A second latching read before any window access replaces the first mask.
- R10: Reset sets every bank register to 0, turns both helper modes off, sets both write-protect bits and drops any latched mask. RAM contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 12 | Offset within the host window |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_sel | input | 2 | Control register select (0 page, 1 middle, 2 top, 3 mode) |
| ctrl_data | input | 8 | Control register write data |

## Verification
The hardest case to reach is a latched mask meeting the bitmap window while other settings are in force. These settings are the AND or OR half of the table, write protection and a steered page. The bench first fills all of RAM with a computed pattern through the low window, so every later read has a known expected value. It then sweeps the latching address across the helper page in both halves. After each latching read it alternates a window read and a window write. It follows up with a plain read, which shows the new byte and that the mask was used exactly once. The bench repeats the sequence with protection on and with two latching reads back to back.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    // Control register selects.
    typedef enum logic [1:0] {
        CSEL_PAGE = 2'd0,
        CSEL_MID  = 2'd1,
        CSEL_HIGH = 2'd2,
        CSEL_MODE = 2'd3
    } csel_e;

    // Window regions.
    typedef enum logic [1:0] {
        RG_PAGE = 2'd0,
        RG_MID  = 2'd1,
        RG_HIGH = 2'd2
    } region_e;

    // Mode register; bit 0 is wp_page.
    typedef struct packed {
        logic mask_en;
        logic steer_en;
        logic wp_mid;
        logic wp_page;
    } mode_t;

    localparam mode_t MODE_RESET = mode_t'(4'b0011);

    // Pending mask operation.
    typedef struct packed {
        logic       valid;
        logic       use_and;
        logic [7:0] mask;
    } pend_t;

    localparam logic [3:0] HELPER_PAGE = 4'hF;

    // Flash contents are a fixed function of the flash address.
    function automatic logic [7:0] flash_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] apply_op(input logic [7:0] cur, input pend_t p);
        return p.use_and ? (cur & p.mask) : (cur | p.mask);
    endfunction

    function automatic region_e region_of(input logic [11:0] off);
        if (off[11])
            return RG_HIGH;
        else if (off[10:8] == 3'd0)
            return RG_PAGE;
        else
            return RG_MID;
    endfunction

endpackage

// File: rtl/pbm_bank_regs.sv
module pbm_bank_regs
    import pbm_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int MID_W  = 4,
    parameter int FBLK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_sel,
    input  logic [7:0]        ctrl_data,
    input  logic              steer_hit,
    input  logic [3:0]        steer_bits,   // host address bits 6..3
    output logic [PAGE_W-1:0] page_q,
    output logic              mid_flash_q,
    output logic [MID_W-1:0]  mid_blk_q,
    output logic [FBLK_W-1:0] high_blk_q,
    output mode_t             mode_q
);

    logic [PAGE_W-1:0] steered;
    logic              unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl_data;

    // Address bit 3 goes to page bit 3, bits 6..4 go to page bits 2..0.
    generate
        if (PAGE_W > 4) begin : g_wide_page
            assign steered = {page_q[PAGE_W-1:4], steer_bits[0], steer_bits[3:1]};
        end else begin : g_narrow_page
            assign steered = {steer_bits[0], steer_bits[3:1]};
        end
    endgenerate

    // A control write to the page register wins over steering in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q      <= '0;
            mid_flash_q <= 1'b0;
            mid_blk_q   <= '0;
            high_blk_q  <= '0;
            mode_q      <= MODE_RESET;
        end else begin
            if (steer_hit)
                page_q <= steered;
            if (ctrl_wr) begin
                case (csel_e'(ctrl_sel))
                    CSEL_PAGE: page_q <= ctrl_data[PAGE_W-1:0];
                    CSEL_MID: begin
                        mid_flash_q <= ctrl_data[7];
                        mid_blk_q   <= ctrl_data[MID_W-1:0];
                    end
                    CSEL_HIGH: high_blk_q <= ctrl_data[FBLK_W-1:0];
                    default:   mode_q     <= mode_t'(ctrl_data[3:0]);
                endcase
            end
        end
    end

endmodule

// File: rtl/pbm_decode.sv
module pbm_decode
    import pbm_pkg::*;
#(
    parameter int RAM_AW   = 12,
    parameter int FLASH_AW = 15,
    parameter int PAGE_W   = 4,
    parameter int MBLK_W   = 1,
    parameter int FBLK_W   = 4,
    parameter int MID_W    = 4
) (
    input  logic [11:0]         host_addr,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [PAGE_W-1:0]   page_q,
    input  logic                mid_flash,
    input  logic [MID_W-1:0]    mid_blk,
    input  logic [FBLK_W-1:0]   high_blk,
    input  mode_t               mode,
    input  pend_t               pend,
    output logic                ram_sel,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                ram_we,
    output logic                rmw_en,
    output logic                op_consume,
    output logic                steer_hit,
    output logic                latch_hit
);

    region_e region;
    logic    acc;
    logic    is_wr;
    logic    helper_pg;
    logic    page_hit;

    always_comb begin
        region     = region_of(host_addr);
        acc        = host_rd | host_wr;
        is_wr      = host_wr & ~host_rd;
        helper_pg  = (host_addr[11:8] == HELPER_PAGE);
        ram_addr   = '0;
        flash_addr = '0;
        ram_sel    = 1'b0;

        case (region)
            RG_PAGE: begin
                ram_addr = {page_q, host_addr[7:0]};
                ram_sel  = 1'b1;
            end
            RG_MID: begin
                ram_addr   = {mid_blk[MBLK_W-1:0], host_addr[10:0]};
                flash_addr = {mid_blk[FBLK_W-1:0], host_addr[10:0]};
                ram_sel    = ~mid_flash;
            end
            default: flash_addr = {high_blk, host_addr[10:0]};
        endcase

        page_hit   = (region == RG_PAGE) && acc;
        op_consume = page_hit && pend.valid;
        rmw_en     = op_consume && !mode.wp_page;
        ram_we     = is_wr &&
                     (((region == RG_PAGE) && !pend.valid && !mode.wp_page) ||
                      ((region == RG_MID) && !mid_flash && !mode.wp_mid));
        steer_hit  = mode.steer_en && acc && helper_pg;
        latch_hit  = mode.mask_en && host_rd && helper_pg;
    end

endmodule

// File: rtl/pbm_op_latch.sv
module pbm_op_latch
    import pbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic       cap_and,
    input  logic [7:0] cap_mask,
    input  logic       consume,
    output pend_t      pend_q
);

    // A capture and a consume never fall on the same access (different regions).
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (capture)
            pend_q <= '{valid: 1'b1, use_and: cap_and, mask: cap_mask};
        else if (consume)
            pend_q <= '0;
    end

endmodule

// File: rtl/pixel_bank_mapper.sv
module pixel_bank_mapper
    import pbm_pkg::*;
#(
    parameter int RAM_AW   = 12,   // 12..16
    parameter int FLASH_AW = 15    // 12..16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        ctrl_wr,
    input  logic [1:0]  ctrl_sel,
    input  logic [7:0]  ctrl_data
);

    localparam int RAM_BYTES = 1 << RAM_AW;
    localparam int PAGE_W    = RAM_AW - 8;
    localparam int MBLK_W    = RAM_AW - 11;
    localparam int FBLK_W    = FLASH_AW - 11;
    localparam int MID_W     = (MBLK_W > FBLK_W) ? MBLK_W : FBLK_W;

    logic [PAGE_W-1:0]   page_q;
    logic                mid_flash_q;
    logic [MID_W-1:0]    mid_blk_q;
    logic [FBLK_W-1:0]   high_blk_q;
    mode_t               mode_q;
    pend_t               pend_q;

    logic                ram_sel;
    logic [RAM_AW-1:0]   ram_addr;
    logic [FLASH_AW-1:0] flash_addr;
    logic                ram_we;
    logic                rmw_en;
    logic                op_consume;
    logic                steer_hit;
    logic                latch_hit;
    logic [7:0]          flash_data;
    logic [7:0]          rdata_q;

    logic [7:0]          ram_mem [RAM_BYTES];

    pbm_bank_regs #(
        .PAGE_W (PAGE_W),
        .MID_W  (MID_W),
        .FBLK_W (FBLK_W)
    ) regs_i (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (ctrl_wr),
        .ctrl_sel    (ctrl_sel),
        .ctrl_data   (ctrl_data),
        .steer_hit   (steer_hit),
        .steer_bits  (host_addr[6:3]),
        .page_q      (page_q),
        .mid_flash_q (mid_flash_q),
        .mid_blk_q   (mid_blk_q),
        .high_blk_q  (high_blk_q),
        .mode_q      (mode_q)
    );

    pbm_decode #(
        .RAM_AW   (RAM_AW),
        .FLASH_AW (FLASH_AW),
        .PAGE_W   (PAGE_W),
        .MBLK_W   (MBLK_W),
        .FBLK_W   (FBLK_W),
        .MID_W    (MID_W)
    ) dec_i (
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .page_q     (page_q),
        .mid_flash  (mid_flash_q),
        .mid_blk    (mid_blk_q),
        .high_blk   (high_blk_q),
        .mode       (mode_q),
        .pend       (pend_q),
        .ram_sel    (ram_sel),
        .ram_addr   (ram_addr),
        .flash_addr (flash_addr),
        .ram_we     (ram_we),
        .rmw_en     (rmw_en),
        .op_consume (op_consume),
        .steer_hit  (steer_hit),
        .latch_hit  (latch_hit)
    );

    assign flash_data = flash_byte(16'(flash_addr));

    pbm_op_latch op_i (
        .clk      (clk),
        .rst      (rst),
        .capture  (latch_hit),
        .cap_and  (host_addr[7]),
        .cap_mask (flash_data),
        .consume  (op_consume),
        .pend_q   (pend_q)
    );

    // Storage: plain write or single-cycle masked update.
    always_ff @(posedge clk) begin
        if (ram_we)
            ram_mem[ram_addr] <= host_wdata;
        else if (rmw_en)
            ram_mem[ram_addr] <= apply_op(ram_mem[ram_addr], pend_q);
    end

    // Registered read path; returns the byte as it was before any update.
    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (host_rd)
            rdata_q <= ram_sel ? ram_mem[ram_addr] : flash_data;
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/pixel_bank_mapper_chk.sv
module pixel_bank_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] host_addr,
    input logic        host_rd,
    input logic        host_wr,
    input logic [7:0]  host_rdata,
    input logic        ctrl_wr,
    input logic [3:0]  page_lo,
    input logic        pend_valid,
    input logic [3:0]  mode_bits,
    input logic        ram_we
);

    logic unused_chk_bits;
    assign unused_chk_bits = ^{host_addr[7], host_addr[2:0]};

    logic in_window;
    logic in_helper;
    logic in_mid;
    assign in_window = (host_addr[11:8] == 4'h0);
    assign in_helper = (host_addr[11:8] == 4'hF);
    assign in_mid    = !host_addr[11] && !in_window;

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (page_lo == 4'h0 && !pend_valid && mode_bits == 4'b0011));

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    assert_latch_arms_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[3] && host_rd && in_helper) |=> pend_valid);

    assert_op_consumed_R9: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && (host_rd || host_wr) && in_window) |=> !pend_valid);

    assert_steer_page_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[2] && (host_rd || host_wr) && in_helper && !ctrl_wr)
        |=> page_lo == {$past(host_addr[3]), $past(host_addr[6:4])});

    assert_wp_window_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[0] && host_wr && !host_rd && in_window) |-> !ram_we);

    assert_wp_mid_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_bits[1] && host_wr && !host_rd && in_mid) |-> !ram_we);

endmodule

bind pixel_bank_mapper pixel_bank_mapper_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .ctrl_wr    (ctrl_wr),
    .page_lo    (page_q[3:0]),
    .pend_valid (pend_q.valid),
    .mode_bits  (mode_q),
    .ram_we     (ram_we)
);

// File: tb/pixel_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module pixel_bank_mapper_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        ctrl_wr = 1'b0;
    logic [1:0]  ctrl_sel = '0;
    logic [7:0]  ctrl_data = '0;

    int total = 0;
    int fails = 0;
    logic [7:0] shadow [4096];

    always #2 clk = ~clk;

    pixel_bank_mapper dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctrl_wr    (ctrl_wr),
        .ctrl_sel   (ctrl_sel),
        .ctrl_data  (ctrl_data)
    );

    function automatic logic [7:0] fl(input int a);
        logic [15:0] x;
        x = a[15:0];
        return x[7:0] ^ {x[11:8], x[15:12]} ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cwr(input int sel, input int d);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_sel = sel[1:0]; ctrl_data = d[7:0];
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic hrd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a[11:0]; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic hwr(input int a, input int d);
        @(negedge clk);
        host_addr = a[11:0]; host_wdata = d[7:0]; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] d, d2, old, nv;
        int o;
        do_reset();

        // Fill all RAM through the low window (R1 path, protection off).
        cwr(3, 0);
        for (int p = 0; p < 16; p++) begin
            cwr(0, p);
            for (int k = 0; k < 256; k++) begin
                nv = 8'((p * 29 + k * 7 + (k >> 3)) & 255);
                hwr(k, nv);
                shadow[p * 256 + k] = nv;
            end
        end

        // R10: reset state, RAM kept.
        do_reset();
        hwr(12'h010, ~shadow[16'h010]);
        hrd(12'h010, d); chk("R10 window protected, page 0", d, shadow[12'h010]);
        hrd(12'h105, d); chk("R10 mid maps RAM block 0", d, shadow[12'h105]);
        hrd(12'hA23, d); chk("R10 top maps flash block 0", d, fl(12'h223));
        hrd(12'hF35, d); chk("R10 top page read", d, fl(12'h735));
        hrd(12'h000, d); chk("R10 helpers off, no steer", d, shadow[0]);
        hrd(12'h000, d); chk("R10 helpers off, no mask", d, shadow[0]);

        // R1: page sweep.
        for (int p = 0; p < 16; p++) begin
            cwr(0, p);
            hrd(12'h000, d); chk("R1 page low", d, shadow[p * 256]);
            hrd(12'h05A, d); chk("R1 page mid", d, shadow[p * 256 + 8'h5A]);
            hrd(12'h0FF, d); chk("R1 page top", d, shadow[p * 256 + 8'hFF]);
        end

        // R2: middle region, RAM block 1 and 0, then flash blocks.
        cwr(1, 1);
        hrd(12'h100, d); chk("R2 RAM blk1", d, shadow[2048 + 12'h100]);
        hrd(12'h456, d); chk("R2 RAM blk1", d, shadow[2048 + 12'h456]);
        hrd(12'h7FF, d); chk("R2 RAM blk1", d, shadow[2048 + 12'h7FF]);
        cwr(1, 0);
        hrd(12'h3C7, d); chk("R2 RAM blk0", d, shadow[12'h3C7]);
        for (int b = 0; b < 16; b++) begin
            cwr(1, 8'h80 | b);
            hrd(12'h3C7, d); chk("R2 flash blk", d, fl(b * 2048 + 12'h3C7));
        end

        // R3: top region sweep.
        for (int b = 0; b < 16; b++) begin
            cwr(2, b);
            hrd(12'h800, d); chk("R3 top", d, fl(b * 2048));
            hrd(12'hABC, d); chk("R3 top", d, fl(b * 2048 + 12'h2BC));
            hrd(12'hFFF, d); chk("R3 top", d, fl(b * 2048 + 12'h7FF));
        end

        // R4: write protection and flash writes.
        cwr(1, 0); cwr(0, 2); cwr(3, 3);
        hwr(12'h020, 8'h5C); hrd(12'h020, d); chk("R4 window wp", d, shadow[12'h220]);
        hwr(12'h300, 8'h5C); hrd(12'h300, d); chk("R4 mid wp", d, shadow[12'h300]);
        cwr(3, 0);
        hwr(12'h020, 8'hC3); shadow[12'h220] = 8'hC3;
        hrd(12'h020, d); chk("R4 window write", d, 8'hC3);
        hwr(12'h300, 8'h3C); shadow[12'h300] = 8'h3C;
        hrd(12'h300, d); chk("R4 mid write", d, 8'h3C);
        cwr(3, 1);
        hwr(12'h300, 8'h99); shadow[12'h300] = 8'h99;
        hrd(12'h300, d); chk("R4 mid open while window wp", d, 8'h99);
        hwr(12'h021, 8'h99); hrd(12'h021, d); chk("R4 window wp only", d, shadow[12'h221]);
        cwr(1, 8'h85);
        hwr(12'h200, 0); hrd(12'h200, d); chk("R4 mid flash write ignored", d, fl(5 * 2048 + 12'h200));
        cwr(1, 0); cwr(2, 3);
        hwr(12'h900, 0); hrd(12'h900, d); chk("R4 top write ignored", d, fl(3 * 2048 + 12'h100));
        hrd(12'h100, d); chk("R4 top write no RAM alias", d, shadow[12'h100]);

        // R5: read data holds.
        hrd(12'h123, d);
        repeat (3) @(negedge clk);
        chk("R5 hold idle", host_rdata, d);
        hwr(12'h124, 8'h6D); shadow[12'h124] = 8'h6D;
        chk("R5 hold across write", host_rdata, d);

        // R6: page steering sweep.
        cwr(3, 4);
        for (int a = 12'hF00; a < 12'hF80; a++) begin
            hrd(a, d);
            hrd(12'h044, d);
            chk("R6 steer", d, shadow[(((a >> 3) & 1) * 8 + ((a >> 4) & 7)) * 256 + 8'h44]);
        end
        hwr(12'hFB9, 0);
        hrd(12'h044, d); chk("R6 steer by write upper half", d, shadow[11 * 256 + 8'h44]);

        // R7/R8/R9: mask latching sweep.
        cwr(3, 8); cwr(2, 6); cwr(0, 5);
        for (int i = 0; i < 16; i++) begin
            int a;
            a = 12'hF00 + i * 12'h011;
            hrd(a, d); chk("R7 latch read data", d, fl(6 * 2048 + (a & 12'h7FF)));
            o = (i * 13) & 255;
            old = shadow[12'h500 + o];
            nv = ((a & 12'h080) != 0) ? (old & d) : (old | d);
            if ((i % 2) == 0) begin
                hrd(o, d2); chk("R8 read returns old byte", d2, old);
            end else begin
                hwr(o, 8'hEE);
            end
            shadow[12'h500 + o] = nv;
            hrd(o, d2); chk("R8 masked update", d2, nv);
            hrd(o, d2); chk("R9 single use", d2, nv);
        end
        hwr(12'h0AB, 8'h77); shadow[12'h5AB] = 8'h77;
        hrd(12'h0AB, d); chk("R9 plain write without latch", d, 8'h77);
        hrd(12'hF12, d);
        hrd(12'hF93, d2);
        old = shadow[12'h5C0];
        hwr(12'h0C0, 0);
        shadow[12'h5C0] = old & d2;
        hrd(12'h0C0, d); chk("R9 second latch replaces first", d, old & d2);

        // R8 under protection, then R9 consumption.
        cwr(3, 9);
        hrd(12'hF05, d);
        hwr(12'h0D0, 8'hFF);
        hrd(12'h0D0, d); chk("R8 wp blocks masked update", d, shadow[12'h5D0]);
        cwr(3, 8);
        hwr(12'h0D0, 8'h33); shadow[12'h5D0] = 8'h33;
        hrd(12'h0D0, d); chk("R9 consumed while protected", d, 8'h33);

        // Pixel plot: steer and latch together.
        cwr(3, 8'h0C);
        hrd(12'hF9A, d);
        old = shadow[9 * 256 + 7];
        hwr(12'h007, 0);
        shadow[9 * 256 + 7] = old & d;
        hrd(12'h007, d2); chk("R6 R8 combined plot", d2, old & d);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule